// File: doc/BRIEF.md
# Exception Entry Controller

This block turns a pending exception into the processor state update that starts its handler. On a request cycle it takes the exception kind, the current program counter, a delay-slot flag, a refill qualifier and the faulting address. It also reads the current status bits (exception level, error level, boot-vector select, user mode, interrupt-vector select), the exception base, the current address-space identifier and the page-table base.

One clock later the registered outputs hold the handler address and the new values of the status bits, the cause fields, the exception-return PC and the error-return PC. For translation-related faults they also hold the bad-address, entry-high and context values. A one-cycle `done_o` pulse marks each accepted entry, and the pipeline uses it to clear its delay-slot flag. An unknown kind raises `bad_o` and changes no state.

The block owns the return and cause registers. It computes the status outputs from the status inputs, apart from the sticky soft-reset and NMI flags, which it keeps itself.

Top module: `excentry_ctrl`

## Requirements
- R1: After reset, the outputs are as follows:
  - `pc_o` is 0xBFC00000.
  - `erl_o` and `bev_o` are 1.
  - Every other output is 0.
- R2: The kind encoding is the cause code itself, plus two extra kinds:
  - Cause kinds: 0 interrupt, 1 TLB modify, 2 TLB load miss, 3 TLB store miss, 4 address error load, 5 address error store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 FP, 23 watch, 24 machine check.
  - Extra kinds: 30 NMI, 31 soft reset.
  - Any other kind pulses `bad_o` for one cycle and leaves every register output unchanged.
- R3: For a general exception the handler base is 0xBFC00200 when `bev_i`=1. Otherwise it is `ebase_i` with bits 9:0 cleared.
- R4: The handler offset is chosen as follows:
  - 0x000 for kinds 2 or 3 with `refill_i`=1 and `exl_i`=0.
  - 0x200 for kind 0 with `iv_i`=1.
  - 0x180 in every other case.
- R5: When `exl_i`=0, a general exception loads `epc_o` and `bd_o`:
  - In a delay slot, `epc_o` gets `pc_i`−4 and `bd_o` becomes 1.
  - Otherwise, `epc_o` gets `pc_i` and `bd_o` becomes 0.
  - When `exl_i`=1, both `epc_o` and `bd_o` keep their values.
- R6: After a general exception, the status outputs are:
  - `exl_o` = 1 and `um_o` = 0.
  - `erl_o` and `bev_o` copy `erl_i` and `bev_i`.
- R7: A general exception writes its kind into the 5-bit `code_o`. Only kind 11 writes `ce_i` into `ce_o`; all other kinds keep `ce_o`.
- R8: NMI and soft reset do the following:
  - Load `errpc_o` with `pc_i`, or `pc_i`−4 in a delay slot.
  - Set `erl_o` and `bev_o` to 1, set `um_o` to 0, and pass `exl_i` through to `exl_o`.
  - Jump to 0xBFC00000.
  - Leave `epc_o`, `bd_o`, `code_o` and `ce_o` unchanged.
  - NMI sets the sticky `nmi_o`, and soft reset sets the sticky `srst_o`.
- R9: Kinds 1 to 5 capture the faulting address into three outputs; all other kinds leave these three outputs unchanged:
  - `badva_o` gets `fault_addr_i`.
  - `entryhi_o` gets {`fault_addr_i`[31:13], 5'b0, `asid_i`}.
  - `context_o` gets {`ptebase_i`, `fault_addr_i`[31:13], 4'b0}.
- R10: Each accepted request gives `done_o`=1 in the next cycle only. `done_o` and `bad_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Exception entry request |
| kind_i | input | 5 | Exception kind (R2 encoding) |
| pc_i | input | 32 | PC of the faulting instruction |
| dslot_i | input | 1 | Fault occurred in a branch delay slot |
| refill_i | input | 1 | TLB miss was a true no-match |
| fault_addr_i | input | 32 | Faulting virtual address |
| ce_i | input | 2 | Coprocessor number for kind 11 |
| exl_i | input | 1 | Current exception-level bit |
| erl_i | input | 1 | Current error-level bit |
| bev_i | input | 1 | Current boot-vector select |
| um_i | input | 1 | Current user-mode bit |
| iv_i | input | 1 | Interrupt special-vector select |
| ebase_i | input | 32 | Exception base register |
| asid_i | input | 8 | Current address-space identifier |
| ptebase_i | input | 9 | Page-table base bits of the context register |
| done_o | output | 1 | Entry completed pulse; clears the delay-slot flag |
| bad_o | output | 1 | Unknown kind pulse |
| pc_o | output | 32 | Handler address |
| epc_o | output | 32 | Exception return PC |
| errpc_o | output | 32 | Error return PC |
| exl_o | output | 1 | New exception-level bit |
| erl_o | output | 1 | New error-level bit |
| bev_o | output | 1 | New boot-vector select |
| um_o | output | 1 | New user-mode bit |
| nmi_o | output | 1 | Sticky NMI flag |
| srst_o | output | 1 | Sticky soft-reset flag |
| bd_o | output | 1 | Branch-delay cause bit |
| code_o | output | 5 | Cause code field |
| ce_o | output | 2 | Coprocessor number cause field |
| badva_o | output | 32 | Bad virtual address |
| entryhi_o | output | 32 | Entry-high value |
| context_o | output | 32 | Context value |

## Verification
Directed requests exercise the following input combinations:
- Interrupts under all four combinations of `bev_i` and `iv_i`, which separate the base selection from the interrupt offset.
- TLB misses with the refill qualifier on and off and with `exl_i` on and off, which isolate the 0x000 offset.
- Delay-slot faults at both exception levels, which tell the PC−4 backup apart from the hold of the return PC.
- NMI, soft reset, kind 11 and unknown kind 14, each checked for the fields they must leave alone.

A seeded random stream then mixes every kind with random status bits and addresses against a bench reference model. This shows that the translation capture fires only for kinds 1 to 5 and that unrelated fields persist across many entries.

// File: rtl/excentry_pkg.sv
package excentry_pkg;

  localparam int KW = 5;

  localparam logic [KW-1:0] K_INT   = 5'd0;
  localparam logic [KW-1:0] K_TMOD  = 5'd1;
  localparam logic [KW-1:0] K_TLD   = 5'd2;
  localparam logic [KW-1:0] K_TST   = 5'd3;
  localparam logic [KW-1:0] K_ADL   = 5'd4;
  localparam logic [KW-1:0] K_ADS   = 5'd5;
  localparam logic [KW-1:0] K_CPU   = 5'd11;
  localparam logic [KW-1:0] K_FPE   = 5'd15;
  localparam logic [KW-1:0] K_WATCH = 5'd23;
  localparam logic [KW-1:0] K_MCHK  = 5'd24;
  localparam logic [KW-1:0] K_NMI   = 5'd30;
  localparam logic [KW-1:0] K_SRST  = 5'd31;

  typedef struct packed {
    logic valid;   // known kind
    logic errlvl;  // NMI or soft reset path
    logic nmi;
    logic srst;
    logic xlat;    // address capture kinds 1..5
    logic miss;    // TLB load/store miss
    logic intr;
    logic cpu;     // coprocessor unusable
  } kind_info_t;

endpackage

// File: rtl/excentry_decode.sv
module excentry_decode
  import excentry_pkg::*;
(
  input  logic [KW-1:0] kind_i,
  output kind_info_t    info_o
);

  always_comb begin
    info_o = '0;
    unique case (kind_i)
      K_INT:                      begin info_o.valid = 1'b1; info_o.intr = 1'b1; end
      K_TMOD, K_ADL, K_ADS:       begin info_o.valid = 1'b1; info_o.xlat = 1'b1; end
      K_TLD, K_TST:               begin info_o.valid = 1'b1; info_o.xlat = 1'b1; info_o.miss = 1'b1; end
      5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd12, 5'd13,
      K_FPE, K_WATCH, K_MCHK:     info_o.valid = 1'b1;
      K_CPU:                      begin info_o.valid = 1'b1; info_o.cpu = 1'b1; end
      K_NMI:                      begin info_o.valid = 1'b1; info_o.errlvl = 1'b1; info_o.nmi = 1'b1; end
      K_SRST:                     begin info_o.valid = 1'b1; info_o.errlvl = 1'b1; info_o.srst = 1'b1; end
      default:                    info_o = '0;
    endcase
  end

endmodule

// File: rtl/excentry_vector.sv
module excentry_vector
  import excentry_pkg::*;
#(
  parameter int              AW       = 32,
  parameter int              ALIGN    = 10,
  parameter logic [AW-1:0]   BOOT_GEN = 32'hBFC0_0200,
  parameter logic [AW-1:0]   BOOT_ERR = 32'hBFC0_0000,
  parameter logic [AW-1:0]   OFF_REF  = 32'h0000_0000,
  parameter logic [AW-1:0]   OFF_IRQ  = 32'h0000_0200,
  parameter logic [AW-1:0]   OFF_GEN  = 32'h0000_0180
) (
  input  kind_info_t    info_i,
  input  logic          bev_i,
  input  logic          exl_i,
  input  logic          iv_i,
  input  logic          refill_i,
  input  logic [AW-1:0] ebase_i,
  output logic [AW-1:0] target_o
);

  logic [AW-1:0] base;
  logic [AW-1:0] offset;
  logic          unused_low;

  assign unused_low = ^ebase_i[ALIGN-1:0];

  always_comb begin
    base = bev_i ? BOOT_GEN : {ebase_i[AW-1:ALIGN], {ALIGN{1'b0}}};
    if (info_i.miss && refill_i && !exl_i) offset = OFF_REF;
    else if (info_i.intr && iv_i)           offset = OFF_IRQ;
    else                                    offset = OFF_GEN;
    target_o = info_i.errlvl ? BOOT_ERR : (base + offset);
  end

endmodule

// File: rtl/excentry_retpc.sv
module excentry_retpc #(
  parameter int AW    = 32,
  parameter int ISTEP = 4
) (
  input  logic [AW-1:0] pc_i,
  input  logic          dslot_i,
  output logic [AW-1:0] ret_o
);

  assign ret_o = dslot_i ? (pc_i - AW'(ISTEP)) : pc_i;

endmodule

// File: rtl/excentry_ctrl.sv
module excentry_ctrl
  import excentry_pkg::*;
#(
  parameter  int AW        = 32,
  parameter  int ASID_W    = 8,
  parameter  int PAGE_BITS = 12,
  parameter  int CTX_LO    = 4,
  localparam int VPN2_W    = AW - PAGE_BITS - 1,
  localparam int PTB_W     = AW - VPN2_W - CTX_LO,
  localparam int EH_GAP    = PAGE_BITS + 1 - ASID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [KW-1:0]     kind_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              dslot_i,
  input  logic              refill_i,
  input  logic [AW-1:0]     fault_addr_i,
  input  logic [1:0]        ce_i,
  input  logic              exl_i,
  input  logic              erl_i,
  input  logic              bev_i,
  input  logic              um_i,
  input  logic              iv_i,
  input  logic [AW-1:0]     ebase_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [PTB_W-1:0]  ptebase_i,
  output logic              done_o,
  output logic              bad_o,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     epc_o,
  output logic [AW-1:0]     errpc_o,
  output logic              exl_o,
  output logic              erl_o,
  output logic              bev_o,
  output logic              um_o,
  output logic              nmi_o,
  output logic              srst_o,
  output logic              bd_o,
  output logic [KW-1:0]     code_o,
  output logic [1:0]        ce_o,
  output logic [AW-1:0]     badva_o,
  output logic [AW-1:0]     entryhi_o,
  output logic [AW-1:0]     context_o
);

  localparam logic [AW-1:0] RST_PC = 32'hBFC0_0000;

  kind_info_t    info;
  logic [AW-1:0] target;
  logic [AW-1:0] ret_pc;
  logic [VPN2_W-1:0] vpn2;

  excentry_decode u_dec (.kind_i(kind_i), .info_o(info));

  excentry_vector #(.AW(AW)) u_vec (
    .info_i(info), .bev_i(bev_i), .exl_i(exl_i), .iv_i(iv_i),
    .refill_i(refill_i), .ebase_i(ebase_i), .target_o(target)
  );

  excentry_retpc #(.AW(AW)) u_ret (.pc_i(pc_i), .dslot_i(dslot_i), .ret_o(ret_pc));

  assign vpn2 = fault_addr_i[AW-1:PAGE_BITS+1];

  // next-state values
  logic              done_d, bad_d, ld_en;
  logic [AW-1:0]     pc_d, epc_d, errpc_d, badva_d, entryhi_d, context_d;
  logic              exl_d, erl_d, bev_d, um_d, nmi_d, srst_d, bd_d;
  logic [KW-1:0]     code_d;
  logic [1:0]        ce_d;
  logic              unused_um;

  assign unused_um = um_i;
  assign ld_en     = req_i && info.valid;

  always_comb begin
    done_d    = 1'b0;
    bad_d     = req_i && !info.valid;
    pc_d      = pc_o;
    epc_d     = epc_o;
    errpc_d   = errpc_o;
    exl_d     = exl_o;
    erl_d     = erl_o;
    bev_d     = bev_o;
    um_d      = um_o;
    nmi_d     = nmi_o;
    srst_d    = srst_o;
    bd_d      = bd_o;
    code_d    = code_o;
    ce_d      = ce_o;
    badva_d   = badva_o;
    entryhi_d = entryhi_o;
    context_d = context_o;
    if (ld_en) begin
      done_d = 1'b1;
      pc_d   = target;
      um_d   = 1'b0;
      if (info.errlvl) begin
        errpc_d = ret_pc;
        erl_d   = 1'b1;
        bev_d   = 1'b1;
        exl_d   = exl_i;
        if (info.nmi)  nmi_d  = 1'b1;
        if (info.srst) srst_d = 1'b1;
      end else begin
        if (!exl_i) begin
          epc_d = ret_pc;
          bd_d  = dslot_i;
        end
        exl_d  = 1'b1;
        erl_d  = erl_i;
        bev_d  = bev_i;
        code_d = kind_i;
        if (info.cpu) ce_d = ce_i;
        if (info.xlat) begin
          badva_d   = fault_addr_i;
          entryhi_d = {vpn2, {EH_GAP{1'b0}}, asid_i};
          context_d = {ptebase_i, vpn2, {CTX_LO{1'b0}}};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      bad_o  <= 1'b0;
    end else begin
      done_o <= done_d;
      bad_o  <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o      <= RST_PC;
      epc_o     <= '0;
      errpc_o   <= '0;
      exl_o     <= 1'b0;
      erl_o     <= 1'b1;
      bev_o     <= 1'b1;
      um_o      <= 1'b0;
      nmi_o     <= 1'b0;
      srst_o    <= 1'b0;
      bd_o      <= 1'b0;
      code_o    <= '0;
      ce_o      <= '0;
      badva_o   <= '0;
      entryhi_o <= '0;
      context_o <= '0;
    end else if (ld_en) begin
      pc_o      <= pc_d;
      epc_o     <= epc_d;
      errpc_o   <= errpc_d;
      exl_o     <= exl_d;
      erl_o     <= erl_d;
      bev_o     <= bev_d;
      um_o      <= um_d;
      nmi_o     <= nmi_d;
      srst_o    <= srst_d;
      bd_o      <= bd_d;
      code_o    <= code_d;
      ce_o      <= ce_d;
      badva_o   <= badva_d;
      entryhi_o <= entryhi_d;
      context_o <= context_d;
    end
  end

endmodule

// File: rtl/excentry_chk.sv
module excentry_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic [4:0]    kind_i,
  input logic          exl_i,
  input logic          done_o,
  input logic          bad_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] epc_o,
  input logic          exl_o,
  input logic          erl_o,
  input logic          bev_o,
  input logic          um_o,
  input logic          bd_o,
  input logic [4:0]    code_o
);

  logic known, errk, genk;

  assign known = (kind_i <= 5'd13) || (kind_i == 5'd15) || (kind_i == 5'd23) ||
                 (kind_i == 5'd24) || (kind_i == 5'd30) || (kind_i == 5'd31);
  assign errk  = (kind_i == 5'd30) || (kind_i == 5'd31);
  assign genk  = known && !errk;

  AST_UNKNOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && !known |=> bad_o && $stable(pc_o) && $stable(epc_o) && $stable(code_o)); // R2

  AST_NESTED_KEEPS_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && genk && exl_i |=> $stable(epc_o) && $stable(bd_o)); // R5

  AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && genk |=> exl_o && !um_o); // R6

  AST_CODE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && genk |=> code_o == $past(kind_i)); // R7

  AST_ERR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && errk |=> pc_o == 32'hBFC0_0000 && erl_o && bev_o && !um_o); // R8

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, bad_o})); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && known |=> done_o); // R10

endmodule

bind excentry_ctrl excentry_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i), .exl_i(exl_i),
  .done_o(done_o), .bad_o(bad_o), .pc_o(pc_o), .epc_o(epc_o), .exl_o(exl_o),
  .erl_o(erl_o), .bev_o(bev_o), .um_o(um_o), .bd_o(bd_o), .code_o(code_o)
);

// File: tb/excentry_ctrl_tb.sv
module excentry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i = 1'b0;
  logic [4:0]  kind_i = '0;
  logic [31:0] pc_i = '0, fault_addr_i = '0, ebase_i = '0;
  logic        dslot_i = 0, refill_i = 0, exl_i = 0, erl_i = 0, bev_i = 0, um_i = 0, iv_i = 0;
  logic [1:0]  ce_i = '0;
  logic [7:0]  asid_i = '0;
  logic [8:0]  ptebase_i = '0;
  logic        done_o, bad_o, exl_o, erl_o, bev_o, um_o, nmi_o, srst_o, bd_o;
  logic [31:0] pc_o, epc_o, errpc_o, badva_o, entryhi_o, context_o;
  logic [4:0]  code_o;
  logic [1:0]  ce_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  excentry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i), .pc_i(pc_i),
    .dslot_i(dslot_i), .refill_i(refill_i), .fault_addr_i(fault_addr_i), .ce_i(ce_i),
    .exl_i(exl_i), .erl_i(erl_i), .bev_i(bev_i), .um_i(um_i), .iv_i(iv_i),
    .ebase_i(ebase_i), .asid_i(asid_i), .ptebase_i(ptebase_i),
    .done_o(done_o), .bad_o(bad_o), .pc_o(pc_o), .epc_o(epc_o), .errpc_o(errpc_o),
    .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o), .um_o(um_o), .nmi_o(nmi_o),
    .srst_o(srst_o), .bd_o(bd_o), .code_o(code_o), .ce_o(ce_o), .badva_o(badva_o),
    .entryhi_o(entryhi_o), .context_o(context_o)
  );

  // reference state
  logic [31:0] m_pc, m_epc, m_errpc, m_badva, m_eh, m_ctx;
  logic        m_done, m_bad, m_exl, m_erl, m_bev, m_um, m_nmi, m_srst, m_bd;
  logic [4:0]  m_code;
  logic [1:0]  m_ce;

  function automatic bit kind_known(input logic [4:0] k);
    return (k <= 5'd13) || k == 5'd15 || k == 5'd23 || k == 5'd24 || k == 5'd30 || k == 5'd31;
  endfunction

  function automatic logic [31:0] gen_vector(input logic [4:0] k, input logic bv, input logic ex,
                                             input logic ivb, input logic rf, input logic [31:0] eb);
    logic [31:0] base, off;
    base = bv ? 32'hBFC0_0200 : (eb & 32'hFFFF_FC00);        // R3
    if ((k == 5'd2 || k == 5'd3) && rf && !ex) off = 32'h000; // R4
    else if (k == 5'd0 && ivb)                 off = 32'h200;
    else                                       off = 32'h180;
    return base + off;
  endfunction

  task automatic model_reset();
    m_pc = 32'hBFC0_0000; m_epc = '0; m_errpc = '0; m_badva = '0; m_eh = '0; m_ctx = '0;
    m_done = 0; m_bad = 0; m_exl = 0; m_erl = 1; m_bev = 1; m_um = 0; m_nmi = 0; m_srst = 0;
    m_bd = 0; m_code = '0; m_ce = '0;
  endtask

  task automatic model_step();
    logic [31:0] rp;
    rp = dslot_i ? pc_i - 32'd4 : pc_i;
    m_done = 0; m_bad = 0;
    if (!kind_known(kind_i)) begin
      m_bad = 1;
    end else if (kind_i >= 5'd30) begin
      m_done = 1; m_pc = 32'hBFC0_0000; m_errpc = rp;
      m_erl = 1; m_bev = 1; m_um = 0; m_exl = exl_i;
      if (kind_i == 5'd30) m_nmi = 1; else m_srst = 1;
    end else begin
      m_done = 1; m_pc = gen_vector(kind_i, bev_i, exl_i, iv_i, refill_i, ebase_i);
      if (!exl_i) begin m_epc = rp; m_bd = dslot_i; end
      m_exl = 1; m_um = 0; m_erl = erl_i; m_bev = bev_i; m_code = kind_i;
      if (kind_i == 5'd11) m_ce = ce_i;
      if (kind_i >= 5'd1 && kind_i <= 5'd5) begin
        m_badva = fault_addr_i;
        m_eh    = {fault_addr_i[31:13], 5'b0, asid_i};
        m_ctx   = {ptebase_i, fault_addr_i[31:13], 4'b0};
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (kind=%0d)", tag, got, exp, kind_i);
    end
  endtask

  task automatic check_all(input string grp);
    chk({grp, " R10 done"}, 32'(done_o), 32'(m_done));
    chk({grp, " R2 bad"}, 32'(bad_o), 32'(m_bad));
    chk({grp, " R3 R4 pc"}, pc_o, m_pc);
    chk({grp, " R5 epc"}, epc_o, m_epc);
    chk({grp, " R5 bd"}, 32'(bd_o), 32'(m_bd));
    chk({grp, " R8 errpc"}, errpc_o, m_errpc);
    chk({grp, " R6 status"}, {28'(0), exl_o, erl_o, bev_o, um_o}, {28'(0), m_exl, m_erl, m_bev, m_um});
    chk({grp, " R8 sticky"}, {30'(0), nmi_o, srst_o}, {30'(0), m_nmi, m_srst});
    chk({grp, " R7 code"}, 32'(code_o), 32'(m_code));
    chk({grp, " R7 ce"}, 32'(ce_o), 32'(m_ce));
    chk({grp, " R9 badva"}, badva_o, m_badva);
    chk({grp, " R9 entryhi"}, entryhi_o, m_eh);
    chk({grp, " R9 context"}, context_o, m_ctx);
  endtask

  task automatic go(input string grp);
    @(negedge clk);
    req_i = 1'b1;
    model_step();
    @(negedge clk);
    req_i = 1'b0;
    check_all(grp);
  endtask

  task automatic setk(input logic [4:0] k, input logic [31:0] p, input logic ds,
                      input logic ex, input logic bv, input logic ivb, input logic rf);
    kind_i = k; pc_i = p; dslot_i = ds; exl_i = ex; bev_i = bv; iv_i = ivb; refill_i = rf;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check_all("reset R1");
    rst_n = 1'b1;

    ebase_i = 32'h8000_13FF; fault_addr_i = 32'h1234_5678; asid_i = 8'h5A; ptebase_i = 9'h155;
    erl_i = 0; ce_i = 2'd2;
    // interrupt, base and offset combinations (R3, R4)
    setk(5'd0, 32'h0000_1000, 0, 0, 1, 1, 0); go("int bev iv");
    setk(5'd0, 32'h0000_1004, 0, 0, 0, 1, 0); go("int ebase iv");
    setk(5'd0, 32'h0000_1008, 0, 0, 0, 0, 0); go("int ebase");
    setk(5'd0, 32'h0000_100C, 0, 0, 1, 0, 0); go("int bev");
    // refill offset (R4) with/without qualifier and nesting
    setk(5'd2, 32'h0000_2000, 0, 0, 0, 0, 1); go("tlbl refill");
    setk(5'd3, 32'h0000_2004, 0, 0, 0, 0, 0); go("tlbs invalid");
    setk(5'd3, 32'h0000_2008, 0, 1, 0, 0, 1); go("tlbs nested");
    // delay slot backup (R5) then nested hold
    setk(5'd8, 32'h0000_3000, 1, 0, 0, 0, 0); go("sys dslot");
    setk(5'd9, 32'h0000_4000, 1, 1, 0, 0, 0); go("brk nested hold R5");
    // coprocessor unusable (R7), non-translation keeps R9 fields
    fault_addr_i = 32'hFEDC_BA98; ce_i = 2'd3;
    setk(5'd11, 32'h0000_5000, 0, 0, 0, 0, 0); go("cpu");
    // NMI and soft reset (R8)
    setk(5'd30, 32'h0000_6004, 1, 0, 0, 0, 0); go("nmi");
    setk(5'd31, 32'h0000_7000, 0, 1, 0, 0, 0); go("srst");
    // unknown kind (R2)
    setk(5'd14, 32'h0000_8000, 0, 0, 0, 0, 0); go("unknown 14");
    setk(5'd27, 32'h0000_8004, 0, 0, 0, 0, 0); go("unknown 27");

    for (int i = 0; i < 400; i++) begin
      logic [4:0] k;
      k = 5'($urandom_range(0, 31));
      if (($urandom & 3) == 0) k = 5'($urandom_range(0, 5));
      kind_i = k; pc_i = $urandom & 32'hFFFF_FFFC; dslot_i = 1'($urandom);
      refill_i = 1'($urandom); exl_i = 1'($urandom); erl_i = 1'($urandom);
      bev_i = 1'($urandom); um_i = 1'($urandom); iv_i = 1'($urandom);
      ebase_i = $urandom; fault_addr_i = $urandom; asid_i = 8'($urandom);
      ptebase_i = 9'($urandom); ce_i = 2'($urandom);
      go("random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule